// File: doc/BRIEF.md
# Periodic Event Timer with Interrupt and Pulse Modes

This block turns one of four timekeeping divider ticks into a periodic event. A 4-bit control register selects the period (1/64 s, 1 s, 1 min or 1 h). It also selects between a latched interrupt mode and a timed pulse mode, and holds a mask bit that blocks new events. One status bit, the event flag, reports activity. The active-low output `event_n` follows that flag.

In interrupt mode the flag is sticky until software writes 0 to it. In pulse mode the flag marks a low pulse on `event_n`. The pulse lasts `PULSE_TICKS` strobes of the 32768 Hz oscillator and then ends by itself. Writing 0 to the flag during a pulse cuts the pulse short. If a control write changes the period or mode bits, any active flag or pulse is dropped.

A three-state machine holds the behaviour:
- `PE_IDLE`: nothing pending.
- `PE_FLAGGED`: an interrupt is latched.
- `PE_PULSING`: a pulse is running.

The transitions are:
- `PE_IDLE` to `PE_FLAGGED` on an unmasked event in interrupt mode.
- `PE_IDLE` to `PE_PULSING` on an unmasked event in pulse mode.
- `PE_FLAGGED` to `PE_IDLE` on a flag write of 0 with no event in the same cycle.
- `PE_PULSING` to `PE_IDLE` on a flag write of 0 (cancel) or on pulse expiry.
- Any state to `PE_IDLE` on a control write that changes bits 3..1 (reconfigure).

Top module: `periodic_event_gen`

## Requirements
- R1: After reset the control register reads 4'b0001 (masked, pulse mode, 1/64 s), `flag_rd` is 0 and `event_n` is 1.
- R2: A control write stores `ctrl_wdata`, and `ctrl_rdata` shows it from the next cycle on. Bit 3..2 is the period code, bit 1 is the mode (1 = interrupt, 0 = pulse) and bit 0 is the mask.
- R3: Period code k selects `period_ticks[k]`: 0 = 1/64 s, 1 = 1 s, 2 = 1 min, 3 = 1 h. Ticks on the other inputs cause no event.
- R4: With the mask bit at 1, no tick starts a new flag or pulse.
- R5: `event_n` equals the inverse of `flag_rd` in every cycle.
- R6: In interrupt mode an unmasked event sets the flag in the next cycle. Writing 0 clears it, and writing 1 has no effect.
- R7: In pulse mode an unmasked event drives `event_n` low for exactly `PULSE_TICKS` `osc_tick` strobes, and the flag ends by itself afterwards.
- R8: Writing 0 to the flag while a pulse is active ends the pulse in the next cycle.
- R9: A control write that changes bits 3..1 clears any flag or pulse in the next cycle. An event in that same cycle is dropped.
- R10: In interrupt mode an event in the same cycle as a flag write of 0 leaves the flag set. In pulse mode an event during an active pulse neither restarts nor extends it.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| period_ticks | input | 4 | One-cycle divider strobes, index = period code |
| osc_tick | input | 1 | 32768 Hz strobe that times the pulse |
| ctrl_we | input | 1 | Control register write enable |
| ctrl_wdata | input | 4 | Control register write data |
| flag_we | input | 1 | Event flag write enable |
| flag_wdata | input | 1 | Event flag write data |
| ctrl_rdata | output | 4 | Control register contents |
| flag_rd | output | 1 | Event flag |
| event_n | output | 1 | Active-low interrupt or pulse output |

## Verification
Every result is due one clock edge after the inputs that cause it. This covers a stored control value, a set or cleared flag, a cancelled pulse and a reconfigure clear, because each passes through only the state or control register. A pulse stays low for `PULSE_TICKS` oscillator strobes counted from the edge that takes the event. The bench drives inputs after a falling edge, advances its reference model at the rising edge, and compares all outputs at the next falling edge. The directed pulse-width check counts low samples one per cycle while the oscillator strobe is held high.

// File: rtl/pe_pkg.sv
package pe_pkg;
    typedef enum logic [1:0] {
        PE_IDLE    = 2'd0,
        PE_FLAGGED = 2'd1,
        PE_PULSING = 2'd2
    } pe_state_e;

    localparam int CTRL_W        = 4;
    localparam int CTRL_MASK_BIT = 0;
    localparam int CTRL_MODE_BIT = 1;
    localparam int SEL_LO_BIT    = 2;
    localparam int SEL_HI_BIT    = 3;
    localparam logic [CTRL_W-1:0] CTRL_RESET = 4'b0001;
endpackage

// File: rtl/pe_tick_select.sv
module pe_tick_select #(
    parameter int NUM_PERIODS = 4,
    localparam int SEL_W = $clog2(NUM_PERIODS)
) (
    input  logic [NUM_PERIODS-1:0] ticks,
    input  logic [SEL_W-1:0]       sel,
    output logic                   tick_out
);
    always_comb begin
        tick_out = ticks[sel];
    end
endmodule

// File: rtl/pe_pulse_timer.sv
module pe_pulse_timer #(
    parameter int PULSE_TICKS = 256,
    localparam int CNT_W = (PULSE_TICKS > 1) ? $clog2(PULSE_TICKS) : 1,
    localparam logic [CNT_W-1:0] CNT_LAST = CNT_W'(PULSE_TICKS - 1)
) (
    input  logic clk,
    input  logic rst_n,
    input  logic load,
    input  logic run,
    input  logic osc_tick,
    output logic expire
);
    logic [CNT_W-1:0] cnt_q;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            cnt_q <= '0;
        end else if (load) begin
            cnt_q <= CNT_LAST;
        end else if (run && osc_tick && (cnt_q != '0)) begin
            cnt_q <= cnt_q - 1'b1;
        end
    end

    always_comb begin
        expire = run && osc_tick && (cnt_q == '0);
    end
endmodule

// File: rtl/periodic_event_gen.sv
module periodic_event_gen
    import pe_pkg::*;
#(
    parameter int PULSE_TICKS = 256,
    parameter int NUM_PERIODS = 4
) (
    input  logic                   clk,
    input  logic                   rst_n,
    input  logic [NUM_PERIODS-1:0] period_ticks,
    input  logic                   osc_tick,
    input  logic                   ctrl_we,
    input  logic [CTRL_W-1:0]      ctrl_wdata,
    input  logic                   flag_we,
    input  logic                   flag_wdata,
    output logic [CTRL_W-1:0]      ctrl_rdata,
    output logic                   flag_rd,
    output logic                   event_n
);
    localparam int SEL_W = $clog2(NUM_PERIODS);

    pe_state_e          state_q, state_d;
    logic [CTRL_W-1:0]  ctrl_q;
    logic               sel_tick;
    logic               period_evt;
    logic               cfg_change;
    logic               clear_wr;
    logic               timer_load;
    logic               timer_expire;

    // control register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            ctrl_q <= CTRL_RESET;
        end else if (ctrl_we) begin
            ctrl_q <= ctrl_wdata;
        end
    end

    pe_tick_select #(.NUM_PERIODS(NUM_PERIODS)) i_sel (
        .ticks    (period_ticks),
        .sel      (ctrl_q[SEL_HI_BIT:SEL_LO_BIT]),
        .tick_out (sel_tick)
    );

    pe_pulse_timer #(.PULSE_TICKS(PULSE_TICKS)) i_timer (
        .clk      (clk),
        .rst_n    (rst_n),
        .load     (timer_load),
        .run      (state_q == PE_PULSING),
        .osc_tick (osc_tick),
        .expire   (timer_expire)
    );

    always_comb begin
        period_evt = sel_tick && !ctrl_q[CTRL_MASK_BIT];
        cfg_change = ctrl_we &&
                     (ctrl_wdata[CTRL_W-1:CTRL_MODE_BIT] != ctrl_q[CTRL_W-1:CTRL_MODE_BIT]);
        clear_wr   = flag_we && !flag_wdata;
    end

    // next-state logic
    always_comb begin
        state_d    = state_q;
        timer_load = 1'b0;
        if (cfg_change) begin
            state_d = PE_IDLE;
        end else begin
            unique case (state_q)
                PE_IDLE: begin
                    if (period_evt) begin
                        if (ctrl_q[CTRL_MODE_BIT]) begin
                            state_d = PE_FLAGGED;
                        end else begin
                            state_d    = PE_PULSING;
                            timer_load = 1'b1;
                        end
                    end
                end
                PE_FLAGGED: begin
                    if (clear_wr && !period_evt) begin
                        state_d = PE_IDLE;
                    end
                end
                PE_PULSING: begin
                    if (clear_wr || timer_expire) begin
                        state_d = PE_IDLE;
                    end
                end
                default: state_d = PE_IDLE;
            endcase
        end
    end

    // state register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state_q <= PE_IDLE;
        end else begin
            state_q <= state_d;
        end
    end

    // outputs
    always_comb begin
        ctrl_rdata = ctrl_q;
        flag_rd    = (state_q != PE_IDLE);
        event_n    = !flag_rd;
    end

    logic unused_sel_w;
    always_comb unused_sel_w = (SEL_W > 0);
endmodule

// File: rtl/pe_checker.sv
module pe_checker (
    input logic       clk,
    input logic       rst_n,
    input logic       ctrl_we,
    input logic [3:0] ctrl_wdata,
    input logic       flag_we,
    input logic       flag_wdata,
    input logic [3:0] ctrl_rdata,
    input logic       flag_rd,
    input logic       event_n
);
    a_r5_out_mirrors_flag: assert property (@(posedge clk) disable iff (!rst_n)
        event_n == !flag_rd);

    a_r2_ctrl_readback: assert property (@(posedge clk) disable iff (!rst_n)
        ctrl_we |=> ctrl_rdata == $past(ctrl_wdata));

    a_r4_mask_blocks: assert property (@(posedge clk) disable iff (!rst_n)
        (!flag_rd && ctrl_rdata[0] && !ctrl_we) |=> !flag_rd);

    a_r6_write_one_ignored: assert property (@(posedge clk) disable iff (!rst_n)
        (flag_rd && ctrl_rdata[1] && flag_we && flag_wdata && !ctrl_we) |=> flag_rd);

    a_r8_cancel_pulse: assert property (@(posedge clk) disable iff (!rst_n)
        (flag_rd && !ctrl_rdata[1] && flag_we && !flag_wdata) |=> !flag_rd);

    a_r9_cfg_change_clears: assert property (@(posedge clk) disable iff (!rst_n)
        (ctrl_we && (ctrl_wdata[3:1] != ctrl_rdata[3:1])) |=> !flag_rd);
endmodule

bind periodic_event_gen pe_checker i_pe_checker (
    .clk        (clk),
    .rst_n      (rst_n),
    .ctrl_we    (ctrl_we),
    .ctrl_wdata (ctrl_wdata),
    .flag_we    (flag_we),
    .flag_wdata (flag_wdata),
    .ctrl_rdata (ctrl_rdata),
    .flag_rd    (flag_rd),
    .event_n    (event_n)
);

// File: tb/test_periodic_event_gen.sv
module test_periodic_event_gen;
    localparam int PULSE = 256;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic [3:0] period_ticks = '0;
    logic       osc_tick = 1'b0;
    logic       ctrl_we = 1'b0;
    logic [3:0] ctrl_wdata = '0;
    logic       flag_we = 1'b0;
    logic       flag_wdata = 1'b0;
    logic [3:0] ctrl_rdata;
    logic       flag_rd;
    logic       event_n;

    int checks = 0;
    int failures = 0;
    bit done = 1'b0;

    // reference model state
    logic [3:0] m_ctrl;
    int         m_st;
    int         m_left;

    always #4 clk = ~clk;

    periodic_event_gen #(.PULSE_TICKS(PULSE)) i_periodic_event_gen (
        .clk(clk), .rst_n(rst_n), .period_ticks(period_ticks), .osc_tick(osc_tick),
        .ctrl_we(ctrl_we), .ctrl_wdata(ctrl_wdata), .flag_we(flag_we),
        .flag_wdata(flag_wdata), .ctrl_rdata(ctrl_rdata), .flag_rd(flag_rd),
        .event_n(event_n)
    );

    task automatic chk(input string req, input int act, input int exp);
        checks++;
        if (act != exp) begin
            failures++;
            $display("FAIL %s actual=%0d expected=%0d at %0t", req, act, exp, $time);
        end
    endtask

    function automatic bit model_event(input logic [3:0] c, input logic [3:0] t);
        return t[c[3:2]] && !c[0];
    endfunction

    task automatic model_update();
        bit cfg = ctrl_we && (ctrl_wdata[3:1] != m_ctrl[3:1]);
        bit evt = model_event(m_ctrl, period_ticks);
        bit clr = flag_we && !flag_wdata;
        if (cfg) m_st = 0;
        else if (m_st == 0) begin
            if (evt) begin
                if (m_ctrl[1]) m_st = 1;
                else begin m_st = 2; m_left = PULSE; end
            end
        end else if (m_st == 1) begin
            if (clr && !evt) m_st = 0;
        end else begin
            if (clr) m_st = 0;
            else if (osc_tick) begin
                m_left--;
                if (m_left == 0) m_st = 0;
            end
        end
        if (ctrl_we) m_ctrl = ctrl_wdata;
    endtask

    // one cycle: inputs already driven after a falling edge
    task automatic step();
        @(posedge clk);
        model_update();
        @(negedge clk);
        chk("R2 ctrl_rdata", int'(ctrl_rdata), int'(m_ctrl));
        chk("R7 flag_rd", int'(flag_rd), int'(m_st != 0));
        chk("R5 event_n", int'(event_n), int'(m_st == 0));
        period_ticks = '0;
        ctrl_we = 1'b0;
        flag_we = 1'b0;
    endtask

    task automatic wr_ctrl(input logic [3:0] v);
        ctrl_we = 1'b1; ctrl_wdata = v; step();
    endtask

    task automatic wr_flag(input logic v);
        flag_we = 1'b1; flag_wdata = v; step();
    endtask

    task automatic fire(input int idx);
        period_ticks[idx] = 1'b1; step();
    endtask

    initial begin
        #1_000_000;
        if (!done) begin
            failures++;
            $display("FAIL watchdog expired");
            $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
            $finish;
        end
    end

    initial begin
        int cnt;
        void'($urandom(32'd4242));
        m_ctrl = 4'b0001; m_st = 0; m_left = 0;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        // R1 reset state
        chk("R1 ctrl reset", int'(ctrl_rdata), 1);
        chk("R1 flag reset", int'(flag_rd), 0);
        chk("R1 event_n reset", int'(event_n), 1);

        // R2 readback: 1 s period, interrupt, unmasked
        wr_ctrl(4'b0110);
        chk("R2 write readback", int'(ctrl_rdata), 6);

        // R3 wrong tick ignored, right tick fires
        fire(0); chk("R3 other tick ignored", int'(flag_rd), 0);
        fire(2); chk("R3 other tick ignored", int'(flag_rd), 0);
        fire(1); chk("R3 selected tick", int'(flag_rd), 1);
        chk("R6 event sets flag", int'(flag_rd), 1);
        chk("R5 output low", int'(event_n), 0);

        // R6 write 1 ignored, write 0 clears
        wr_flag(1'b1); chk("R6 write one ignored", int'(flag_rd), 1);
        wr_flag(1'b0); chk("R6 write zero clears", int'(flag_rd), 0);

        // R10 event beats clear in interrupt mode
        fire(1);
        period_ticks[1] = 1'b1; flag_we = 1'b1; flag_wdata = 1'b0; step();
        chk("R10 event wins over clear", int'(flag_rd), 1);
        wr_flag(1'b0);

        // R4 mask
        wr_ctrl(4'b0111);
        fire(1); fire(1); chk("R4 masked", int'(flag_rd), 0);

        // R7 pulse width, R10 no extension during pulse
        osc_tick = 1'b1;
        wr_ctrl(4'b0000);
        fire(0);
        cnt = 0;
        while (flag_rd && cnt < PULSE + 20) begin
            cnt++;
            if (cnt == 100) period_ticks[0] = 1'b1;
            step();
        end
        chk("R7 pulse width", cnt, PULSE);
        chk("R10 pulse not extended", int'(flag_rd), 0);

        // R8 cancel
        fire(0);
        repeat (10) step();
        wr_flag(1'b0); chk("R8 cancel pulse", int'(flag_rd), 0);

        // R9 reconfigure clears pulse and drops same-cycle event
        fire(0); chk("R9 pulse active", int'(flag_rd), 1);
        ctrl_we = 1'b1; ctrl_wdata = 4'b0010; period_ticks[0] = 1'b1; step();
        chk("R9 cfg change clears", int'(flag_rd), 0);
        fire(0); chk("R9 new cfg interrupt", int'(flag_rd), 1);
        ctrl_we = 1'b1; ctrl_wdata = 4'b0100; period_ticks = 4'b1111; step();
        chk("R9 event dropped on change", int'(flag_rd), 0);

        // random phase
        for (int i = 0; i < 20000; i++) begin
            osc_tick = ($urandom % 4) != 0;
            for (int b = 0; b < 4; b++) period_ticks[b] = ($urandom % 40) == 0;
            if (($urandom % 200) == 0) begin
                ctrl_we = 1'b1; ctrl_wdata = 4'($urandom);
            end
            if (($urandom % 30) == 0) begin
                flag_we = 1'b1; flag_wdata = 1'($urandom);
            end
            step();
        end

        done = 1'b1;
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end
endmodule